// File: doc/BRIEF.md
# Up/Down PWM Timer with Input Capture

The block is a 16-bit timer/counter for a microcontroller-class subsystem. A clock-select field picks the count rate: stopped, every system clock, one of four fixed divisions of the system clock, or edges of an external count pin. The count source and all pins are synchronous to the system clock. A capture pin copies the running count into a capture register on a chosen edge, so software can timestamp external events.

The timer runs either as a plain wrapping up-counter or as a symmetric (phase-correct) PWM generator. In PWM mode the counter ramps from zero up to a resolution-dependent ceiling and back down. The PWM pin switches whenever the count meets a compare value. Compare writes made in PWM mode are held in a shadow register and only reach the comparator when the count sits at the ceiling, so no period is ever generated from a half-updated threshold. Overflow, compare-match and capture events each raise a sticky flag. Registers are read and written as whole 16-bit words over a simple synchronous write port and a combinational read port.

Top module: `ptc_timer`

Register map (2-bit address): 0 = control, 1 = count, 2 = compare, 3 = capture on read / flag clear on write. Control byte: bits [2:0] clock select, bits [4:3] PWM resolution, bits [6:5] output mode, bit 7 capture edge.

## Requirements
- R1: After reset the count, compare, capture and control registers read 0, all three flags are 0 and the PWM pin is 0.
- R2: The clock-select field (control bits [2:0]) counts as follows: 000 no counting, 001 one step per system clock, 010 one step per 8 clocks, 011 per 64, 100 per 256, 101 per 1024; any window whose length is a multiple of the divider holds exactly length/divider steps.
- R3: With code 110 the counter steps once per falling edge of the external count pin and with code 111 once per rising edge, the pin passing a two-stage synchronizer first; edges of the other polarity do not step it.
- R4: A write to the count register loads the written value at that clock edge, overriding any step due in the same cycle, and counting resumes from that value on the next timer step.
- R5: With PWM resolution 00 the counter counts up, wraps from 0xFFFF to 0x0000 and then sets the overflow flag; compare writes take effect at once and reaching the compare value sets the compare flag.
- R6: PWM resolution codes 01, 10, 11 select a ceiling of 0x00FF, 0x01FF, 0x03FF; the counter runs 0 up to the ceiling and back down, a full cycle being twice the ceiling in steps, and the overflow flag sets each time the count arrives at 0.
- R7: In PWM mode a compare write lands in a shadow register; the comparator keeps using its previous value until the count equals the ceiling, while a read of the compare register always returns the latest write.
- R8: Output mode (control bits [6:5]) 10 is non-inverting: the pin goes low when the count reaches the compare value heading upward and high when it reaches it heading downward; 11 inverts both; 00 and 01 hold the pin low.
- R9: A compare value of 0 or of the ceiling gives a steady level: in mode 10, 0 gives a constant low and the ceiling a constant high; in mode 11 the opposite.
- R10: With capture-edge bit 7 = 1 a rising edge of the synchronized capture pin, and with bit 7 = 0 a falling edge, copies the count into the capture register and sets the capture flag; the other edge changes neither.
- R11: Writing address 3 clears the overflow, compare and capture flags for each 1 in data bits 0, 1 and 2; a pulse on the overflow acknowledge input also clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External count pin (asynchronous) |
| cap_pin | input | 1 | Capture trigger pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ovf_ack | input | 1 | Overflow acknowledge, clears the overflow flag |
| pwm_out | output | 1 | PWM output pin |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |
| cap_flag | output | 1 | Capture flag |

## Verification
A timer step is due one clock edge after the cycle in which the selected source ticks, and flags set at that same edge, so the bench drives on falling edges and reads right after the rising edge of interest; single steps are produced by two back-to-back control writes that leave the source at code 001 for exactly one cycle. Divided rates are checked over windows that are whole multiples of the divider, which makes the step count exact whatever the prescaler phase. Pin events pass two synchronizer stages plus an edge register, about three edges, so the bench waits four or five cycles before reading. PWM duty and period are taken from counts of high cycles over one full 510-cycle period after a settling delay, and from the edge count between two overflow flags.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int CW    = 16;  // counter and register width
    localparam int PRE_W = 10;  // prescaler width, covers the largest divider
    localparam int AW    = 2;   // register address width
    localparam int CTRLW = 8;   // control byte width

    typedef enum logic [2:0] {
        CS_STOP     = 3'b000,
        CS_DIV1     = 3'b001,
        CS_DIV8     = 3'b010,
        CS_DIV64    = 3'b011,
        CS_DIV256   = 3'b100,
        CS_DIV1024  = 3'b101,
        CS_EXT_FALL = 3'b110,
        CS_EXT_RISE = 3'b111
    } clk_sel_e;

    typedef enum logic [1:0] {
        RES_OFF = 2'b00,
        RES_8   = 2'b01,
        RES_9   = 2'b10,
        RES_10  = 2'b11
    } pwm_res_e;

    typedef enum logic [1:0] {
        OM_LOW0  = 2'b00,
        OM_LOW1  = 2'b01,
        OM_NONINV = 2'b10,
        OM_INV   = 2'b11
    } out_mode_e;

    typedef struct packed {
        logic      cap_rise;
        out_mode_e omode;
        pwm_res_e  res;
        clk_sel_e  csel;
    } ctrl_t;

    localparam logic [AW-1:0] A_CTRL = 2'd0;
    localparam logic [AW-1:0] A_CNT  = 2'd1;
    localparam logic [AW-1:0] A_CMP  = 2'd2;
    localparam logic [AW-1:0] A_CAP  = 2'd3;

    // Mask of prescaler bits that must all be ones for a divided tick.
    function automatic logic [PRE_W-1:0] div_mask(clk_sel_e s);
        case (s)
            CS_DIV8:    return PRE_W'(10'h007);
            CS_DIV64:   return PRE_W'(10'h03F);
            CS_DIV256:  return PRE_W'(10'h0FF);
            CS_DIV1024: return PRE_W'(10'h3FF);
            default:    return '0;
        endcase
    endfunction

    // Turn-around value of the up/down ramp for a resolution code.
    function automatic logic [CW-1:0] top_of(pwm_res_e r);
        case (r)
            RES_8:   return CW'(16'h00FF);
            RES_9:   return CW'(16'h01FF);
            RES_10:  return CW'(16'h03FF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler
    import ptc_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e csel,
    input  logic     ext_clk,
    output logic     tick
);

    logic [PRE_W-1:0] pre_q;
    logic [SYNC:0]    ext_sh;
    logic             ext_now, ext_prev;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            ext_sh <= '0;
        end else begin
            pre_q  <= pre_q + 1'b1;
            ext_sh <= {ext_sh[SYNC-1:0], ext_clk};
        end
    end

    assign ext_now  = ext_sh[SYNC-1];
    assign ext_prev = ext_sh[SYNC];
    assign mask     = div_mask(csel);

    always_comb begin
        case (csel)
            CS_STOP:     tick = 1'b0;
            CS_EXT_FALL: tick = ext_prev & ~ext_now;
            CS_EXT_RISE: tick = ext_now & ~ext_prev;
            default:     tick = ((pre_q & mask) == mask);
        endcase
    end

    // R2: a divide-by-8 source never ticks on two consecutive cycles
    p_div_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (csel == CS_DIV8 && $past(csel) == CS_DIV8 && tick) |-> !$past(tick));

endmodule

// File: rtl/ptc_capture.sv
module ptc_capture
    import ptc_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_pin,
    input  logic          rise_sel,
    input  logic [CW-1:0] cnt,
    input  logic          clr,
    output logic [CW-1:0] cap_q,
    output logic          cap_flag
);

    logic [SYNC:0] cap_sh;
    logic          evt;

    always_ff @(posedge clk) begin
        if (rst) cap_sh <= '0;
        else     cap_sh <= {cap_sh[SYNC-1:0], cap_pin};
    end

    assign evt = rise_sel ? (cap_sh[SYNC-1] & ~cap_sh[SYNC])
                          : (~cap_sh[SYNC-1] & cap_sh[SYNC]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q    <= '0;
            cap_flag <= 1'b0;
        end else begin
            if (evt) cap_q <= cnt;
            if (evt)      cap_flag <= 1'b1;
            else if (clr) cap_flag <= 1'b0;
        end
    end

    // R10: an event latches the count seen in that cycle and raises the flag
    p_cap_latch_r10: assert property (@(posedge clk) disable iff (rst)
        evt |=> (cap_flag && cap_q == $past(cnt)));

    // R10: without an event the capture register keeps its value
    p_cap_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(cap_q));

endmodule

// File: rtl/ptc_core.sv
module ptc_core
    import ptc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  pwm_res_e      res,
    input  out_mode_e     omode,
    input  logic          cnt_we,
    input  logic          cmp_we,
    input  logic [CW-1:0] wdata,
    input  logic          ovf_clr,
    input  logic          cmp_clr,
    input  logic          ovf_ack,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cmp_view,
    output logic          pwm_out,
    output logic          ovf_flag,
    output logic          cmp_flag
);

    logic [CW-1:0] top;
    logic [CW-1:0] nxt;
    logic [CW-1:0] cmp_act;
    logic          pwm_on;
    logic          up_q, nxt_up;
    logic          step, hit, wrap, out_q;

    assign pwm_on = (res != RES_OFF);
    assign top    = top_of(res);
    assign step   = tick & ~cnt_we;

    // Next count and the direction of travel away from it.
    always_comb begin
        nxt    = cnt_q + 1'b1;
        nxt_up = 1'b1;
        if (pwm_on) begin
            if (up_q && cnt_q >= top) begin
                nxt    = cnt_q - 1'b1;
                nxt_up = 1'b0;
            end else if (!up_q && cnt_q == '0) begin
                nxt    = CW'(1);
                nxt_up = (top != CW'(1));
            end else if (up_q) begin
                nxt    = cnt_q + 1'b1;
                nxt_up = (nxt != top);
            end else begin
                nxt    = cnt_q - 1'b1;
                nxt_up = (nxt == '0);
            end
        end
    end

    assign hit  = step && (nxt == cmp_act);
    assign wrap = step && (nxt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else begin
            if (cnt_we)    cnt_q <= wdata;
            else if (step) cnt_q <= nxt;
            if (!pwm_on)   up_q <= 1'b1;
            else if (step) up_q <= nxt_up;
        end
    end

    // Shadow and active compare registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_view <= '0;
            cmp_act  <= '0;
        end else begin
            if (cmp_we) cmp_view <= wdata;
            if (!pwm_on) begin
                if (cmp_we) cmp_act <= wdata;
            end else if (cnt_q == top) begin
                cmp_act <= cmp_view;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else if (!pwm_on) begin
            out_q <= 1'b0;
        end else if (hit) begin
            case (omode)
                OM_NONINV: out_q <= ~nxt_up;
                OM_INV:    out_q <= nxt_up;
                default:   out_q <= out_q;
            endcase
        end
    end

    assign pwm_out = pwm_on & omode[1] & out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            if (wrap)                    ovf_flag <= 1'b1;
            else if (ovf_clr || ovf_ack) ovf_flag <= 1'b0;
            if (hit)          cmp_flag <= 1'b1;
            else if (cmp_clr) cmp_flag <= 1'b0;
        end
    end

    // R4: a timer step moves the count by exactly one
    p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
        step |=> ((cnt_q - $past(cnt_q)) == CW'(1) || ($past(cnt_q) - cnt_q) == CW'(1)));

    // R2: no tick and no write leaves the count alone
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_we) |=> $stable(cnt_q));

    // R6: an in-range PWM count stays in range
    p_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        (pwm_on && cnt_q <= top && !cnt_we && $stable(res)) |=> (cnt_q <= $past(top)));

    // R7: away from the ceiling the active compare value is frozen
    p_shadow_r7: assert property (@(posedge clk) disable iff (rst)
        (pwm_on && cnt_q != top) |=> $stable(cmp_act));

    // R8: the output level only changes on a compare hit
    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (pwm_on && !hit) |=> $stable(out_q));

    // R6: arriving at zero raises the overflow flag
    p_ovf_set_r6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_flag);

endmodule

// File: rtl/ptc_timer.sv
module ptc_timer
    import ptc_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_clk,
    input  logic          cap_pin,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data,
    input  logic          ovf_ack,
    output logic          pwm_out,
    output logic          ovf_flag,
    output logic          cmp_flag,
    output logic          cap_flag
);

    ctrl_t         ctrl_q;
    logic          tick;
    logic [CW-1:0] cnt_q, cmp_view, cap_q;
    logic          flag_wr;

    always_ff @(posedge clk) begin
        if (rst)                              ctrl_q <= '0;
        else if (wr_en && wr_addr == A_CTRL)  ctrl_q <= ctrl_t'(wr_data[CTRLW-1:0]);
    end

    assign flag_wr = wr_en && (wr_addr == A_CAP);

    ptc_prescaler #(.SYNC(SYNC)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .csel    (ctrl_q.csel),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    ptc_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .res      (ctrl_q.res),
        .omode    (ctrl_q.omode),
        .cnt_we   (wr_en && wr_addr == A_CNT),
        .cmp_we   (wr_en && wr_addr == A_CMP),
        .wdata    (wr_data),
        .ovf_clr  (flag_wr && wr_data[0]),
        .cmp_clr  (flag_wr && wr_data[1]),
        .ovf_ack  (ovf_ack),
        .cnt_q    (cnt_q),
        .cmp_view (cmp_view),
        .pwm_out  (pwm_out),
        .ovf_flag (ovf_flag),
        .cmp_flag (cmp_flag)
    );

    ptc_capture #(.SYNC(SYNC)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap_pin  (cap_pin),
        .rise_sel (ctrl_q.cap_rise),
        .cnt      (cnt_q),
        .clr      (flag_wr && wr_data[2]),
        .cap_q    (cap_q),
        .cap_flag (cap_flag)
    );

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {{(CW-CTRLW){1'b0}}, ctrl_q};
            A_CNT:   rd_data = cnt_q;
            A_CMP:   rd_data = cmp_view;
            default: rd_data = cap_q;
        endcase
    end

    // R11: a clearing write with no new event drops the overflow flag
    p_ovf_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && wr_data[0] && !(tick && cnt_q == '1 && ctrl_q.res == RES_OFF)
         && ctrl_q.res == RES_OFF && !(wr_addr == A_CNT)) |=> !ovf_flag);

endmodule

// File: tb/sim_ptc_timer.sv
module sim_ptc_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        ext_clk, cap_pin, wr_en, ovf_ack;
    logic [1:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;
    logic        pwm_out, ovf_flag, cmp_flag, cap_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ptc_timer u0 (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .cap_pin(cap_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ovf_ack(ovf_ack),
        .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
        .cap_flag(cap_flag)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One register write; returns at the falling edge after the write edge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    // Exactly one timer step: source at code 001 for a single cycle.
    task automatic one_step(input logic [15:0] base);
        wr(2'd0, base | 16'h0001);
        wr(2'd0, base);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1", "register after reset", v, 0);
        end
        chk("R1", "flags after reset", {ovf_flag, cmp_flag, cap_flag}, 0);
        chk("R1", "pwm pin after reset", pwm_out, 0);
    endtask

    task automatic t_prescale;
        logic [15:0] a, b;
        int codes [6] = '{0, 1, 2, 3, 4, 5};
        int lens  [6] = '{50, 100, 80, 320, 1024, 3072};
        int exps  [6] = '{0, 100, 10, 5, 4, 3};
        for (int i = 0; i < 6; i++) begin
            wr(2'd0, 16'h0000);
            wr(2'd1, 16'h0000);
            wr(2'd0, 16'(codes[i]));
            rd(2'd1, a);
            repeat (lens[i]) @(negedge clk);
            rd(2'd1, b);
            chk("R2", $sformatf("steps for clock code %0d", codes[i]), b - a, exps[i]);
        end
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_external;
        logic [15:0] v;
        wr(2'd0, 16'h0007);
        wr(2'd1, 16'h0000);
        for (int i = 0; i < 3; i++) begin
            ext_clk = 1'b1; repeat (4) @(negedge clk);
            ext_clk = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(2'd1, v);
        chk("R3", "rising-edge external count", v, 3);
        wr(2'd0, 16'h0006);
        wr(2'd1, 16'h0000);
        for (int i = 0; i < 2; i++) begin
            ext_clk = 1'b1; repeat (4) @(negedge clk);
            ext_clk = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(2'd1, v);
        chk("R3", "falling-edge external count", v, 2);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_load;
        logic [15:0] v;
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h0500);
        rd(2'd1, v);
        chk("R4", "count right after write", v, 16'h0500);
        @(negedge clk);
        rd(2'd1, v);
        chk("R4", "count one step after write", v, 16'h0501);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_normal;
        logic [15:0] v;
        wr(2'd1, 16'h0030);
        wr(2'd2, 16'h0031);
        one_step(16'h0000);
        chk("R5", "compare flag on match", cmp_flag, 1);
        wr(2'd3, 16'h0002);
        chk("R11", "compare flag cleared", cmp_flag, 0);
        wr(2'd1, 16'hFFFE);
        wr(2'd0, 16'h0001);
        @(negedge clk);
        rd(2'd1, v);
        chk("R5", "count at 0xFFFF", v, 16'hFFFF);
        chk("R5", "no overflow before wrap", ovf_flag, 0);
        @(negedge clk);
        rd(2'd1, v);
        chk("R5", "count wrapped", v, 16'h0000);
        chk("R5", "overflow on wrap", ovf_flag, 1);
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h0001);
        chk("R11", "overflow cleared by write", ovf_flag, 0);
        wr(2'd1, 16'hFFFF);
        one_step(16'h0000);
        chk("R11", "overflow set again", ovf_flag, 1);
        ovf_ack = 1'b1;
        @(posedge clk); #1;
        ovf_ack = 1'b0;
        @(negedge clk);
        chk("R11", "overflow cleared by acknowledge", ovf_flag, 0);
    endtask

    task automatic t_period(input logic [15:0] resbits, input int top);
        int n;
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        wr(2'd0, resbits | 16'h0001);
        n = 0;
        while (!ovf_flag && n < 5000) begin @(negedge clk); n++; end
        wr(2'd3, 16'h0001);
        n = 0;
        while (!ovf_flag && n < 5000) begin @(negedge clk); n++; end
        chk("R6", $sformatf("edges between overflows, top 0x%0h", top), n, 2 * top - 1);
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h0001);
    endtask

    task automatic t_shadow;
        logic [15:0] v;
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h0011);
        wr(2'd1, 16'h0010);
        wr(2'd0, 16'h0008);
        wr(2'd2, 16'h0012);
        rd(2'd2, v);
        chk("R7", "compare read returns latest write", v, 16'h0012);
        wr(2'd3, 16'h0002);
        one_step(16'h0008);
        chk("R7", "old compare still active", cmp_flag, 1);
        wr(2'd3, 16'h0002);
        one_step(16'h0008);
        chk("R7", "new compare not yet active", cmp_flag, 0);
        wr(2'd1, 16'h00FF);
        wr(2'd3, 16'h0002);
        wr(2'd1, 16'h0011);
        one_step(16'h0008);
        chk("R7", "new compare active after ceiling", cmp_flag, 1);
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h0002);
    endtask

    task automatic t_duty(input string req, input int mode, input logic [15:0] cmpv,
                          input int exp);
        int h;
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        wr(2'd2, cmpv);
        wr(2'd0, 16'(mode << 5) | 16'h0009);
        repeat (600) @(negedge clk);
        h = 0;
        for (int i = 0; i < 510; i++) begin
            if (pwm_out) h++;
            @(negedge clk);
        end
        chk(req, $sformatf("high cycles, mode %0d compare 0x%0h", mode, cmpv), h, exp);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_capture;
        logic [15:0] v;
        wr(2'd0, 16'h0080);
        wr(2'd1, 16'h1234);
        cap_pin = 1'b1; repeat (5) @(negedge clk);
        chk("R10", "flag on rising edge", cap_flag, 1);
        rd(2'd3, v);
        chk("R10", "captured count", v, 16'h1234);
        cap_pin = 1'b0; repeat (5) @(negedge clk);
        wr(2'd3, 16'h0004);
        chk("R11", "capture flag cleared", cap_flag, 0);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h2222);
        cap_pin = 1'b1; repeat (5) @(negedge clk);
        chk("R10", "rising edge ignored in falling mode", cap_flag, 0);
        rd(2'd3, v);
        chk("R10", "capture unchanged by ignored edge", v, 16'h1234);
        cap_pin = 1'b0; repeat (5) @(negedge clk);
        chk("R10", "flag on falling edge", cap_flag, 1);
        rd(2'd3, v);
        chk("R10", "captured on falling edge", v, 16'h2222);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; ext_clk = 1'b0; cap_pin = 1'b0; wr_en = 1'b0; ovf_ack = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_external();
        t_load();
        t_normal();
        t_period(16'h0010, 16'h01FF);
        t_period(16'h0018, 16'h03FF);
        t_shadow();
        t_duty("R8", 2, 16'h0040, 128);
        t_duty("R8", 3, 16'h0040, 382);
        t_duty("R8", 1, 16'h0040, 0);
        t_duty("R9", 2, 16'h0000, 0);
        t_duty("R9", 2, 16'h00FF, 510);
        t_duty("R9", 3, 16'h0000, 510);
        t_capture();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule